// File: doc/BRIEF.md
# Regulator Configuration and Event-Flag Register Bank

This block is the byte-wide register file behind a digitally controlled voltage regulator. A host-side bus bridge (not part of this block) presents single-cycle reads and writes on a small address/data port. The block holds four read/write configuration registers and one status register.

- The configuration registers drive decoded control fields straight to the regulator's control logic: the voltage code, the range and soft-start selections, the ramp rate, the enables, and two single-bit options.
- The status register collects six event pulses from the power stage into sticky flags. Reading the status register clears them.

The voltage code and the range selection do not have fixed reset values. They are taken from two strap inputs, which are captured while the synchronous reset is held low. A self-clearing bit in the first control register acts as a software reset. It returns every register to its power-up value, including the strapped ones, using the captured strap values rather than the current pin levels. The forced-PWM output is asserted when either the register bit or the external mode pin requests it.

Top module: `vreg_cfg_regs`

## Requirements
- R1: Registers are decoded at `bus_addr` 0 (voltage code), 1 (control A), 2 (control B), 3 (control C) and 4 (event flags). `rd_data` shows the addressed register combinationally. Addresses 5 to 7 read 0x00, and writes to them change nothing.
- R2: Control A fields are packed as follows, with bit 7 always reading 0:
  - bit 6: spread-spectrum enable
  - bit 5: switching enable
  - bit 4: forced-PWM request
  - bit 3: discharge enable
  - bit 2: hiccup enable
  - bits 1:0: ramp code
  
  Its value after reset is 0x2A.
- R3: A write to control A with bit 7 set discards the rest of that write. At that clock edge it restores every register to its reset value: voltage code and range from the captured straps, control A 0x2A, control B soft-start 01b, control C 0x00, and flags 0x02.
- R4: In control B, bits 7:4 read 0 and ignore writes, bits 3:2 hold the range code, and bits 1:0 hold the soft-start code (reset value 01b). In control C, bits 7:2 read 0 and ignore writes, bit 1 is the single-operation option, and bit 0 is the power-good blanking option.
- R5: While `rst_n` is low, `strap_vcode` and `strap_range` are captured and loaded into the voltage code and the range field. Pin changes after `rst_n` rises have no effect, including on a later software reset.
- R6: Event flags occupy bits 5:0 of the status register. An `evt_in[k]` high in a cycle sets flag k at that clock edge. Flags stay set until the status register is read. Bits 7:6 read 0. The flag order from bit 5 down is:
  - hiccup
  - current limit
  - thermal warning
  - thermal shutdown
  - undervoltage
  - overvoltage
- R7: A read of address 4 (`rd_en` high) returns the flags as they were before the clock edge, then clears them at that edge.
- R8: An event arriving in the same cycle as a status read leaves its flag set after the clear.
- R9: After reset the status register reads 0x02, with only the undervoltage flag set.
- R10: `fpwm_on` is high when the forced-PWM bit of control A is 1 or `mode_pin` is 1.
- R11: Writes to the status register are ignored and leave all flags unchanged.
- R12: Every decoded output port follows its register field from the clock edge that writes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; straps sampled while low |
| bus_addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe; a read of address 4 clears the flags |
| rd_data | output | 8 | Read data for `bus_addr` |
| strap_vcode | input | 8 | Strapped reset value of the voltage code |
| strap_range | input | 2 | Strapped reset value of the range code |
| evt_in | input | 6 | Event pulses, bit order as in R6 |
| mode_pin | input | 1 | External forced-PWM request |
| vcode | output | 8 | Voltage code |
| range_sel | output | 2 | Range code |
| ss_sel | output | 2 | Soft-start code |
| ramp_sel | output | 2 | Ramp code |
| spread_en | output | 1 | Spread-spectrum enable |
| sw_en | output | 1 | Switching enable |
| fpwm_on | output | 1 | Effective forced-PWM mode |
| dischg_en | output | 1 | Discharge enable |
| hiccup_en | output | 1 | Hiccup enable |
| single_op | output | 1 | Single-operation option |
| pg_blank | output | 1 | Power-good blanking option |

## Verification
The properties assume the bridge never raises `wr_en` and `rd_en` in the same cycle. They also assume `evt_in` and the bus strobes are meaningful only once `rst_n` is high. The stimulus drives every operation as a single-strobe cycle set up on the falling edge. Events are applied either alone or together with a status read, and never together with a write. The software-reset property takes for granted that a write with bit 7 set reaches only control A. The stimulus therefore issues that write at address 1 and no other address.

// File: rtl/vreg_cfg_pkg.sv
// Package: shared constants and field layouts for the regulator register bank.
// Assumes byte-wide registers and an address space of eight locations.
package vreg_cfg_pkg;

    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 3;
    localparam int NUM_EVT = 6;
    localparam int CODE_W  = 2;

    localparam logic [ADDR_W-1:0] A_VCODE = 3'd0;
    localparam logic [ADDR_W-1:0] A_CTLA  = 3'd1;
    localparam logic [ADDR_W-1:0] A_CTLB  = 3'd2;
    localparam logic [ADDR_W-1:0] A_CTLC  = 3'd3;
    localparam logic [ADDR_W-1:0] A_FLAGS = 3'd4;

    // Control A: bit 7 is the self-clearing software reset, not stored.
    typedef struct packed {
        logic              spread;
        logic              sw_en;
        logic              fpwm;
        logic              dischg;
        logic              hiccup;
        logic [CODE_W-1:0] ramp;
    } ctla_t;

    typedef struct packed {
        logic [CODE_W-1:0] range;
        logic [CODE_W-1:0] sstime;
    } ctlb_t;

    typedef struct packed {
        logic single;
        logic pgblank;
    } ctlc_t;

    localparam int CTLA_W = $bits(ctla_t);
    localparam int CTLB_W = $bits(ctlb_t);
    localparam int CTLC_W = $bits(ctlc_t);

    localparam ctla_t CTLA_DFLT = '{spread: 1'b0, sw_en: 1'b1, fpwm: 1'b0,
                                    dischg: 1'b1, hiccup: 1'b0, ramp: 2'b10};
    localparam logic [CODE_W-1:0]  SS_DFLT    = 2'b01;
    localparam ctlc_t              CTLC_DFLT  = '{single: 1'b0, pgblank: 1'b0};
    localparam logic [NUM_EVT-1:0] FLAGS_DFLT = 6'b00_0010;

endpackage

// File: rtl/vreg_ctrl_file.sv
// Module: read/write configuration registers with strapped reset values.
// Assumes wr_en is a one-cycle strobe and that straps are stable while rst_n is low.
module vreg_ctrl_file
    import vreg_cfg_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic [DATA_W-1:0]         strap_vcode,
    input  logic [CODE_W-1:0]         strap_range,
    output logic                      soft_rst,
    output logic [DATA_W-1:0]         vcode_q,
    output ctla_t                     ctla_q,
    output ctlb_t                     ctlb_q,
    output ctlc_t                     ctlc_q
);

    logic [DATA_W-1:0] strap_vcode_q;
    logic [CODE_W-1:0] strap_range_q;

    // Decode a write of control A with the reset bit set.
    assign soft_rst = wr_en && (addr == A_CTLA) && wr_data[DATA_W-1];

    // Hold the strap levels seen during hardware reset for later software resets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strap_vcode_q <= strap_vcode;
            strap_range_q <= strap_range;
        end
    end

    // Update the configuration registers from reset, software reset or bus writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vcode_q <= strap_vcode;
            ctla_q  <= CTLA_DFLT;
            ctlb_q  <= '{range: strap_range, sstime: SS_DFLT};
            ctlc_q  <= CTLC_DFLT;
        end else if (soft_rst) begin
            vcode_q <= strap_vcode_q;
            ctla_q  <= CTLA_DFLT;
            ctlb_q  <= '{range: strap_range_q, sstime: SS_DFLT};
            ctlc_q  <= CTLC_DFLT;
        end else if (wr_en) begin
            case (addr)
                A_VCODE: vcode_q <= wr_data;
                A_CTLA:  ctla_q  <= ctla_t'(wr_data[CTLA_W-1:0]);
                A_CTLB:  ctlb_q  <= ctlb_t'(wr_data[CTLB_W-1:0]);
                A_CTLC:  ctlc_q  <= ctlc_t'(wr_data[CTLC_W-1:0]);
                default: ;
            endcase
        end
    end

    // Software reset must leave control A at its defaults on the next cycle.
    p_soft_dflt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (ctla_q == CTLA_DFLT) && (ctlc_q == CTLC_DFLT)
                     && (ctlb_q.sstime == SS_DFLT));

    // Without a write no configuration field may move (R1, R12).
    p_cfg_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(vcode_q) && $stable(ctla_q) && $stable(ctlb_q) && $stable(ctlc_q));

endmodule

// File: rtl/vreg_evt_flags.sv
// Module: sticky event flags, cleared by a status read, with a coincident event kept.
// Assumes evt_in pulses are synchronous to clk.
module vreg_evt_flags
    import vreg_cfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_in,
    input  logic               rd_clr,
    input  logic               soft_rst,
    output logic [NUM_EVT-1:0] flags_q
);

    logic [NUM_EVT-1:0] keep_mask;

    // Select which stored flags survive this cycle.
    assign keep_mask = rd_clr ? '0 : flags_q;

    // Latch events on top of the surviving flags.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) flags_q <= FLAGS_DFLT;
        else                    flags_q <= keep_mask | evt_in;
    end

    // An event always shows up in the following cycle (R6, R8).
    p_evt_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_rst |=> ((flags_q & $past(evt_in)) == $past(evt_in)));

    // After a status read only newly arrived events remain.
    p_clr_on_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !soft_rst) |=> ((flags_q & ~$past(evt_in)) == '0));

    // Without a read a set flag never drops (R6, R11).
    p_flag_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_clr && !soft_rst) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

    // Software reset brings the flags back to their power-up pattern.
    p_flag_dflt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (flags_q == FLAGS_DFLT));

endmodule

// File: rtl/vreg_rd_mux.sv
// Module: read-data selector; reserved bits and unlisted addresses read zero.
// Assumes purely combinational use by the bus bridge.
module vreg_rd_mux
    import vreg_cfg_pkg::*;
(
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  vcode_q,
    input  ctla_t              ctla_q,
    input  ctlb_t              ctlb_q,
    input  ctlc_t              ctlc_q,
    input  logic [NUM_EVT-1:0] flags_q,
    output logic [DATA_W-1:0]  rd_data
);

    // Pick the addressed register and zero-extend it.
    always_comb begin
        case (addr)
            A_VCODE: rd_data = vcode_q;
            A_CTLA:  rd_data = {{(DATA_W-CTLA_W){1'b0}}, ctla_q};
            A_CTLB:  rd_data = {{(DATA_W-CTLB_W){1'b0}}, ctlb_q};
            A_CTLC:  rd_data = {{(DATA_W-CTLC_W){1'b0}}, ctlc_q};
            A_FLAGS: rd_data = {{(DATA_W-NUM_EVT){1'b0}}, flags_q};
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/vreg_cfg_regs.sv
// Module: top of the regulator register bank; ties the register file, the
// event flags and the read selector together and decodes the output fields.
// Assumes wr_en and rd_en are never high in the same cycle.
module vreg_cfg_regs
    import vreg_cfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  bus_addr,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    input  logic        rd_en,
    output logic [7:0]  rd_data,
    input  logic [7:0]  strap_vcode,
    input  logic [1:0]  strap_range,
    input  logic [5:0]  evt_in,
    input  logic        mode_pin,
    output logic [7:0]  vcode,
    output logic [1:0]  range_sel,
    output logic [1:0]  ss_sel,
    output logic [1:0]  ramp_sel,
    output logic        spread_en,
    output logic        sw_en,
    output logic        fpwm_on,
    output logic        dischg_en,
    output logic        hiccup_en,
    output logic        single_op,
    output logic        pg_blank
);

    logic               soft_rst;
    logic               rd_clr;
    ctla_t              ctla_q;
    ctlb_t              ctlb_q;
    ctlc_t              ctlc_q;
    logic [NUM_EVT-1:0] flags_q;

    // A read strobe on the status address clears the flags.
    assign rd_clr = rd_en && (bus_addr == A_FLAGS);

    vreg_ctrl_file u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .addr        (bus_addr),
        .wr_data     (wr_data),
        .strap_vcode (strap_vcode),
        .strap_range (strap_range),
        .soft_rst    (soft_rst),
        .vcode_q     (vcode),
        .ctla_q      (ctla_q),
        .ctlb_q      (ctlb_q),
        .ctlc_q      (ctlc_q)
    );

    vreg_evt_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_in   (evt_in),
        .rd_clr   (rd_clr),
        .soft_rst (soft_rst),
        .flags_q  (flags_q)
    );

    vreg_rd_mux u_mux (
        .addr    (bus_addr),
        .vcode_q (vcode),
        .ctla_q  (ctla_q),
        .ctlb_q  (ctlb_q),
        .ctlc_q  (ctlc_q),
        .flags_q (flags_q),
        .rd_data (rd_data)
    );

    // Fan the stored fields out to the regulator control ports.
    assign range_sel = ctlb_q.range;
    assign ss_sel    = ctlb_q.sstime;
    assign ramp_sel  = ctla_q.ramp;
    assign spread_en = ctla_q.spread;
    assign sw_en     = ctla_q.sw_en;
    assign dischg_en = ctla_q.dischg;
    assign hiccup_en = ctla_q.hiccup;
    assign single_op = ctlc_q.single;
    assign pg_blank  = ctlc_q.pgblank;
    assign fpwm_on   = ctla_q.fpwm | mode_pin;

    // The bridge contract: never a read and a write together.
    p_bus_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && rd_en));

endmodule

// File: tb/test_vreg_cfg_regs.sv
`timescale 1ns/1ps
module test_vreg_cfg_regs;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic [7:0] strap_vcode = 8'h5C;
    logic [1:0] strap_range = 2'b10;
    logic [5:0] evt_in = '0;
    logic       mode_pin = 1'b0;
    logic [7:0] vcode;
    logic [1:0] range_sel, ss_sel, ramp_sel;
    logic       spread_en, sw_en, fpwm_on, dischg_en, hiccup_en, single_op, pg_blank;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    vreg_cfg_regs i_vreg_cfg_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .strap_vcode(strap_vcode), .strap_range(strap_range),
        .evt_in(evt_in), .mode_pin(mode_pin), .vcode(vcode),
        .range_sel(range_sel), .ss_sel(ss_sel), .ramp_sel(ramp_sel),
        .spread_en(spread_en), .sw_en(sw_en), .fpwm_on(fpwm_on),
        .dischg_en(dischg_en), .hiccup_en(hiccup_en),
        .single_op(single_op), .pg_blank(pg_blank)
    );

    // Vector: {req[3:0], op[1:0] (0 wr, 1 rd, 2 idle), addr[2:0], data[7:0], evt[5:0], exp[7:0]}
    localparam int NV = 26;
    localparam logic [30:0] VEC [0:NV-1] = '{
        {4'd5,  2'd1, 3'd0, 8'h00, 6'h00, 8'h5C},  // R5 strapped code
        {4'd2,  2'd1, 3'd1, 8'h00, 6'h00, 8'h2A},  // R2 control A default
        {4'd4,  2'd1, 3'd2, 8'h00, 6'h00, 8'h09},  // R4 range strap + soft-start 01
        {4'd4,  2'd1, 3'd3, 8'h00, 6'h00, 8'h00},  // R4 control C default
        {4'd9,  2'd1, 3'd4, 8'h00, 6'h00, 8'h02},  // R9 undervoltage set
        {4'd7,  2'd1, 3'd4, 8'h00, 6'h00, 8'h00},  // R7 cleared by read
        {4'd12, 2'd0, 3'd0, 8'h7E, 6'h00, 8'h00},  // R12 write code
        {4'd12, 2'd1, 3'd0, 8'h00, 6'h00, 8'h7E},  // R12
        {4'd4,  2'd0, 3'd2, 8'hFF, 6'h00, 8'h00},  // R4
        {4'd4,  2'd1, 3'd2, 8'h00, 6'h00, 8'h0F},  // R4 reserved stay 0
        {4'd4,  2'd0, 3'd3, 8'hFF, 6'h00, 8'h00},  // R4
        {4'd4,  2'd1, 3'd3, 8'h00, 6'h00, 8'h03},  // R4
        {4'd2,  2'd0, 3'd1, 8'h55, 6'h00, 8'h00},  // R2
        {4'd2,  2'd1, 3'd1, 8'h00, 6'h00, 8'h55},  // R2
        {4'd11, 2'd0, 3'd4, 8'hFF, 6'h00, 8'h00},  // R11 write status
        {4'd11, 2'd1, 3'd4, 8'h00, 6'h00, 8'h00},  // R11 unchanged
        {4'd1,  2'd0, 3'd5, 8'hFF, 6'h00, 8'h00},  // R1 unlisted write
        {4'd1,  2'd1, 3'd5, 8'h00, 6'h00, 8'h00},  // R1
        {4'd1,  2'd1, 3'd7, 8'h00, 6'h00, 8'h00},  // R1
        {4'd1,  2'd1, 3'd0, 8'h00, 6'h00, 8'h7E},  // R1 code untouched
        {4'd6,  2'd2, 3'd0, 8'h00, 6'h21, 8'h00},  // R6 hiccup + overvoltage
        {4'd6,  2'd1, 3'd4, 8'h00, 6'h00, 8'h21},  // R6
        {4'd7,  2'd1, 3'd4, 8'h00, 6'h00, 8'h00},  // R7
        {4'd8,  2'd1, 3'd4, 8'h00, 6'h04, 8'h00},  // R8 event during read
        {4'd8,  2'd1, 3'd4, 8'h00, 6'h00, 8'h04},  // R8 survived
        {4'd7,  2'd1, 3'd4, 8'h00, 6'h00, 8'h00}   // R7
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic bus(input logic [1:0] op, input logic [2:0] a, input logic [7:0] d,
                       input logic [5:0] ev);
        @(negedge clk);
        wr_en    = (op == 2'd0);
        rd_en    = (op == 2'd1);
        bus_addr = a;
        wr_data  = d;
        evt_in   = ev;
        #1;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
        bus(2'd1, a, 8'h00, 6'h00);
        check(req, rd_data, exp);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        strap_vcode = 8'hA3;   // R5: later pin changes must be ignored
        strap_range = 2'b01;
        #1;
        check("R9", {sw_en, dischg_en, ramp_sel, ss_sel, range_sel}, 8'b1110_0110);

        for (int i = 0; i < NV; i++) begin
            bus(VEC[i][26:25], VEC[i][24:22], VEC[i][21:14], VEC[i][13:8]);
            if (VEC[i][26:25] == 2'd1)
                check($sformatf("R%0d", VEC[i][30:27]), rd_data, VEC[i][7:0]);
        end
        bus(2'd2, 3'd0, 8'h00, 6'h00);

        // R12: decoded outputs after 0x55 / 0x0F / 0x03 / 0x7E
        check("R12", {1'b0, spread_en, sw_en, fpwm_on, dischg_en, hiccup_en, ramp_sel}, 8'h55);
        check("R12", vcode, 8'h7E);
        check("R12", {4'b0, range_sel, ss_sel}, 8'h0F);
        check("R12", {6'b0, single_op, pg_blank}, 8'h03);

        // R10: OR of the register bit and the mode pin
        bus(2'd0, 3'd1, 8'h45, 6'h00);
        bus(2'd2, 3'd0, 8'h00, 6'h00);
        check("R10", {7'b0, fpwm_on}, 8'h00);
        mode_pin = 1'b1; #1;
        check("R10", {7'b0, fpwm_on}, 8'h01);
        bus(2'd0, 3'd1, 8'h10, 6'h00);
        bus(2'd2, 3'd0, 8'h00, 6'h00);
        mode_pin = 1'b0; #1;
        check("R10", {7'b0, fpwm_on}, 8'h01);

        // R3: software reset with flags set and changed strap pins
        bus(2'd2, 3'd0, 8'h00, 6'h3F);
        bus(2'd0, 3'd1, 8'hFF, 6'h00);
        bus(2'd2, 3'd0, 8'h00, 6'h00);
        rd_chk("R3", 3'd0, 8'h5C);
        rd_chk("R3", 3'd1, 8'h2A);
        rd_chk("R3", 3'd2, 8'h09);
        rd_chk("R3", 3'd3, 8'h00);
        rd_chk("R3", 3'd4, 8'h02);
        bus(2'd2, 3'd0, 8'h00, 6'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog all-reqs actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule